// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

The block sits in a memory controller's data path and turns a single column access command into the column address for each data beat of that burst. A READ or WRITE command brings an address word, a bank number and a copy of the mode register. The address word holds both the start column and the auto-precharge request. From these the block steps through the burst in either sequential or interleaved wrap order. Each step is triggered by a beat-advance strobe from the data path.

Two device organisations are supported, chosen by a parameter. The narrow one has a 10-bit column. The wide one has an 11-bit column, whose top bit comes from the address bit just above the auto-precharge bit. The auto-precharge bit is removed from the column and travels with the burst. When a burst that asked for auto-precharge ends, the block sends a one-cycle precharge request that carries the burst's bank. A new command always takes over at the next edge. This allows bursts to run back to back, and it also allows a burst to be cut short.

Top module: `ddr_burst_colseq`

## Requirements
- R1: The column comes from addr_i[9:0] in the narrow organisation. In the wide organisation it is {addr_i[11], addr_i[9:0]}. addr_i[10] is the auto-precharge request and never appears in the column.
- R2: mode_i[2:0] sets the burst length: 3'b001 gives 2 beats, 3'b010 gives 4, 3'b011 gives 8, and every other code gives 2. mode_i[3] selects the order: 0 is sequential and 1 is interleaved. Length, order, start column, bank and auto-precharge are captured on the edge where cmd_valid_i is high.
- R3: In the cycle after a command edge, active_o is high and col_o shows beat 0, which is the start column.
- R4: In sequential order, the low log2(BL) column bits of beat n equal (start + n) mod BL. The upper column bits keep their start value.
- R5: In interleaved order, the low log2(BL) column bits of beat n equal start XOR n. The upper column bits keep their start value.
- R6: The beat index moves forward only on an edge where beat_i is high. While beat_i is low, col_o holds its value.
- R7: last_o is high exactly while the active burst shows beat BL-1.
- R8: The edge where beat_i is high during the last beat ends the burst, and active_o is low in the next cycle unless a command arrived on that edge. If auto-precharge was captured, pre_req_o is high for exactly that next cycle, with pre_bank_o equal to the burst's bank.
- R9: bank_o holds the captured bank for the whole burst.
- R10: A command on the same edge that ends a burst starts the new burst at beat 0 in the next cycle. The finished burst still issues its precharge request.
- R11: A command on any other edge while a burst is active cuts that burst short. The cut burst issues no precharge request.
- R12: While rst_ni is low, active_o, last_o and pre_req_o are low.
- R13: beat_i has no effect while no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; commands and beats sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | READ/WRITE command accepted this edge |
| addr_i | input | ADDR_W (13) | Command address word: column bits and auto-precharge bit |
| bank_i | input | BANK_W (2) | Bank number of the command |
| mode_i | input | 4 | Mode image: [2:0] length code, [3] order |
| beat_i | input | 1 | Advance to the next beat |
| col_o | output | COL_W (10 or 11) | Column address of the current beat |
| bank_o | output | BANK_W (2) | Bank of the current burst |
| active_o | output | 1 | A burst beat is presented |
| last_o | output | 1 | Current beat is the final beat |
| pre_req_o | output | 1 | One-cycle auto-precharge request |
| pre_bank_o | output | BANK_W (2) | Bank for the precharge request |

## Verification
The bench builds two instances from the same stimulus: one with the default narrow organisation and one with WIDE_ORG set to 1. This compares both column maps under identical traffic. It shows that address bit 11 moves into column bit 10 only in the wide build, and that bit 10 stays out of the column in both. Random mode images reach every length code, including the codes that fall back to length 2, and both wrap orders at every start offset. Random command timing places commands on final beats and on middle beats, and combines stalls with bursts that are cut short.

// File: rtl/ddr_colseq_pkg.sv
package ddr_colseq_pkg;

  localparam int unsigned CNT_W = 3;

  typedef enum logic {
    ORD_SEQ  = 1'b0,
    ORD_INTL = 1'b1
  } burst_ord_e;

  typedef struct packed {
    logic [1:0] len_log2;
    burst_ord_e ord;
  } burst_mode_t;

  function automatic burst_mode_t decode_mode(input logic [3:0] m);
    burst_mode_t r;
    case (m[2:0])
      3'b010:  r.len_log2 = 2'd2;
      3'b011:  r.len_log2 = 2'd3;
      default: r.len_log2 = 2'd1;
    endcase
    r.ord = burst_ord_e'(m[3]);
    return r;
  endfunction

endpackage

// File: rtl/colseq_addr_split.sv
module colseq_addr_split #(
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned AP_BIT   = 10,
  parameter bit          WIDE_ORG = 1'b0,
  parameter int unsigned COL_W    = AP_BIT + (WIDE_ORG ? 1 : 0)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [COL_W-1:0]  col_o,
  output logic              ap_o
);

  assign ap_o = addr_i[AP_BIT];

  generate
    if (WIDE_ORG) begin : g_wide
      // column skips the precharge bit
      assign col_o = {addr_i[AP_BIT+1], addr_i[AP_BIT-1:0]};
      if (ADDR_W > AP_BIT + 2) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^addr_i[ADDR_W-1:AP_BIT+2];
      end
    end else begin : g_narrow
      assign col_o = addr_i[AP_BIT-1:0];
      logic unused_hi;
      assign unused_hi = ^addr_i[ADDR_W-1:AP_BIT+1];
    end
  endgenerate

endmodule

// File: rtl/colseq_wrap_gen.sv
module colseq_wrap_gen
  import ddr_colseq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] start_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       len_log2_i,
  input  burst_ord_e       ord_i,
  output logic [COL_W-1:0] col_o
);

  logic [CNT_W-1:0] lmask;
  logic [CNT_W-1:0] slo;
  logic [CNT_W-1:0] lo;

  always_comb begin
    lmask = CNT_W'((4'd1 << len_log2_i) - 4'd1);
    slo   = start_i[CNT_W-1:0];
    lo    = (ord_i == ORD_INTL) ? (slo ^ cnt_i) : (slo + cnt_i);
    col_o = (start_i & ~COL_W'(lmask)) | COL_W'(lo & lmask);
  end

endmodule

// File: rtl/colseq_beat_ctrl.sv
module colseq_beat_ctrl
  import ddr_colseq_pkg::*;
#(
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_i,
  input  logic              beat_i,
  input  logic [1:0]        len_log2_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              ap_i,
  output logic              active_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [1:0]        len_log2_o,
  output logic              last_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              pre_req_o,
  output logic [BANK_W-1:0] pre_bank_o
);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        len_q;
  logic [BANK_W-1:0] bank_q;
  logic              ap_q;
  logic              pre_q;
  logic [BANK_W-1:0] pre_bank_q;
  logic [CNT_W-1:0]  last_idx;
  logic              fin;

  assign last_idx = CNT_W'((4'd1 << len_q) - 4'd1);
  assign last_o   = active_q && (cnt_q == last_idx);
  assign fin      = last_o && beat_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      len_q    <= 2'd1;
      bank_q   <= '0;
      ap_q     <= 1'b0;
    end else if (cmd_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      len_q    <= len_log2_i;
      bank_q   <= bank_i;
      ap_q     <= ap_i;
    end else if (active_q && beat_i) begin
      if (fin) active_q <= 1'b0;
      else     cnt_q    <= cnt_q + 1'b1;
    end
  end

  // precharge only for a burst that ran to its end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q      <= 1'b0;
      pre_bank_q <= '0;
    end else begin
      pre_q <= fin && ap_q;
      if (fin) pre_bank_q <= bank_q;
    end
  end

  assign active_o   = active_q;
  assign cnt_o      = cnt_q;
  assign len_log2_o = len_q;
  assign bank_o     = bank_q;
  assign pre_req_o  = pre_q;
  assign pre_bank_o = pre_bank_q;

  AST_START_BEAT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i |=> (active_o && cnt_o == '0)) else $error("start");  // R3
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !beat_i && !cmd_i) |=> $stable(cnt_o)) else $error("stall");  // R6
  AST_PRE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_req_o |-> $past(last_o && beat_i)) else $error("pre src");  // R8
  AST_PRE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_req_o |=> !pre_req_o) else $error("pre len");  // R8
  AST_BANK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !cmd_i && !fin) |=> $stable(bank_o)) else $error("bank");  // R9
  AST_IDLE_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !cmd_i) |=> !active_o) else $error("idle");  // R13

endmodule

// File: rtl/ddr_burst_colseq.sv
module ddr_burst_colseq
  import ddr_colseq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned AP_BIT   = 10,
  parameter int unsigned BANK_W   = 2,
  parameter bit          WIDE_ORG = 1'b0,
  localparam int unsigned COL_W   = AP_BIT + (WIDE_ORG ? 1 : 0)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [3:0]        mode_i,
  input  logic              beat_i,
  output logic [COL_W-1:0]  col_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              active_o,
  output logic              last_o,
  output logic              pre_req_o,
  output logic [BANK_W-1:0] pre_bank_o
);

  logic [COL_W-1:0] cmd_col;
  logic             cmd_ap;
  burst_mode_t      cmd_mode;
  logic [COL_W-1:0] start_q;
  burst_ord_e       ord_q;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       len_log2;

  assign cmd_mode = decode_mode(mode_i);

  colseq_addr_split #(
    .ADDR_W  (ADDR_W),
    .AP_BIT  (AP_BIT),
    .WIDE_ORG(WIDE_ORG),
    .COL_W   (COL_W)
  ) u_split (
    .addr_i(addr_i),
    .col_o (cmd_col),
    .ap_o  (cmd_ap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      ord_q   <= ORD_SEQ;
    end else if (cmd_valid_i) begin
      start_q <= cmd_col;
      ord_q   <= cmd_mode.ord;
    end
  end

  colseq_beat_ctrl #(
    .BANK_W(BANK_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd_valid_i),
    .beat_i    (beat_i),
    .len_log2_i(cmd_mode.len_log2),
    .bank_i    (bank_i),
    .ap_i      (cmd_ap),
    .active_o  (active_o),
    .cnt_o     (cnt),
    .len_log2_o(len_log2),
    .last_o    (last_o),
    .bank_o    (bank_o),
    .pre_req_o (pre_req_o),
    .pre_bank_o(pre_bank_o)
  );

  colseq_wrap_gen #(
    .COL_W(COL_W)
  ) u_wrap (
    .start_i   (start_q),
    .cnt_i     (cnt),
    .len_log2_i(len_log2),
    .ord_i     (ord_q),
    .col_o     (col_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!active_o && !last_o && !pre_req_o)) else $error("reset");  // R12
  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && beat_i && !cmd_valid_i) |=> !active_o) else $error("end");  // R8

endmodule

// File: tb/ddr_burst_colseq_bench.sv
`timescale 1ns/1ps
module ddr_burst_colseq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd = 1'b0;
  logic [12:0] addr = '0;
  logic [1:0]  bank = '0;
  logic [3:0]  mode = '0;
  logic        beat = 1'b0;

  logic [10:0] col_w;
  logic [9:0]  col_n;
  logic [1:0]  bank_w, bank_n, pbank_w, pbank_n;
  logic        act_w, act_n, last_w, last_n, pre_w, pre_n;

  int vectors = 0;
  int errors  = 0;

  always #2.5 clk = ~clk;

  ddr_burst_colseq #(.WIDE_ORG(1'b1)) u_ddr_burst_colseq (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd), .addr_i(addr), .bank_i(bank),
    .mode_i(mode), .beat_i(beat), .col_o(col_w), .bank_o(bank_w), .active_o(act_w),
    .last_o(last_w), .pre_req_o(pre_w), .pre_bank_o(pbank_w)
  );

  ddr_burst_colseq #(.WIDE_ORG(1'b0)) u_ddr_burst_colseq_nar (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd), .addr_i(addr), .bank_i(bank),
    .mode_i(mode), .beat_i(beat), .col_o(col_n), .bank_o(bank_n), .active_o(act_n),
    .last_o(last_n), .pre_req_o(pre_n), .pre_bank_o(pbank_n)
  );

  // behavioural reference
  int m_act, m_cnt, m_bl, m_intl, m_sw, m_sn, m_bank, m_ap, m_pre, m_pbank;

  function automatic int exp_col(int start, int bl, int intl, int n);
    int lo;
    lo = intl ? ((start % bl) ^ n) : ((start + n) % bl);
    return start - (start % bl) + lo;
  endfunction

  function automatic int len_of(int m);
    case (m % 8)
      2: return 4;
      3: return 8;
      default: return 2;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_cnt = 0; m_bl = 2; m_intl = 0; m_sw = 0; m_sn = 0;
      m_bank = 0; m_ap = 0; m_pre = 0; m_pbank = 0;
    end else begin
      int done;
      done = (m_act != 0) && beat && (m_cnt == m_bl - 1);
      m_pre = done && (m_ap != 0);
      if (done) m_pbank = m_bank;
      if (cmd) begin
        m_act = 1; m_cnt = 0;
        m_bl = len_of(int'(mode)); m_intl = (int'(mode) / 8) % 2;
        m_sn = int'(addr) % 1024;
        m_sw = int'(addr) % 1024 + ((int'(addr) / 2048) % 2) * 1024;
        m_ap = (int'(addr) / 1024) % 2;
        m_bank = int'(bank);
      end else if (m_act != 0 && beat) begin
        if (done) m_act = 0;
        else m_cnt = m_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R12 reset active", int'(act_w) + int'(act_n), 0);
      chk("R12 reset last", int'(last_w) + int'(last_n), 0);
      chk("R12 reset pre_req", int'(pre_w) + int'(pre_n), 0);
    end else begin
      chk("R3 R8 R10 R13 active wide", int'(act_w), m_act);
      chk("R3 R8 R10 R13 active narrow", int'(act_n), m_act);
      chk("R7 last wide", int'(last_w), int'(m_act != 0 && m_cnt == m_bl - 1));
      chk("R7 last narrow", int'(last_n), int'(m_act != 0 && m_cnt == m_bl - 1));
      chk("R8 R10 R11 pre_req wide", int'(pre_w), m_pre);
      chk("R8 R10 R11 pre_req narrow", int'(pre_n), m_pre);
      if (m_pre != 0) begin
        chk("R8 pre_bank wide", int'(pbank_w), m_pbank);
        chk("R8 pre_bank narrow", int'(pbank_n), m_pbank);
      end
      if (m_act != 0) begin
        chk("R1 R2 R4 R5 R6 col wide", int'(col_w), exp_col(m_sw, m_bl, m_intl, m_cnt));
        chk("R1 R2 R4 R5 R6 col narrow", int'(col_n), exp_col(m_sn, m_bl, m_intl, m_cnt));
        chk("R9 bank wide", int'(bank_w), m_bank);
        chk("R9 bank narrow", int'(bank_n), m_bank);
      end
    end
  end

  task automatic step(input bit c, input int a, input int b, input int m, input bit bt);
    @(negedge clk);
    cmd = c; addr = 13'(a); bank = 2'(b); mode = 4'(m); beat = bt;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13: beats while idle
    repeat (3) step(0, 0, 0, 0, 1);
    // R4 wide map with bit11 and AP, stall mid-burst (R6)
    step(1, 2048 + 1024 + 13, 2, 4'h3, 0);
    step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    repeat (7) step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    // R5 interleaved length 4 with AP
    step(1, 1024 + 6, 1, 4'hA, 1);
    repeat (5) step(0, 0, 0, 0, 1);
    // R10 back-to-back: command on the ending edge
    step(1, 1024 + 3, 3, 4'h1, 1);
    step(0, 0, 0, 0, 1);
    step(1, 1024 + 2048 + 5, 0, 4'hB, 1);
    repeat (8) step(0, 0, 0, 0, 1);
    // R11 truncation of an AP burst
    step(1, 1024 + 7, 2, 4'h3, 1);
    step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 1);
    step(1, 9, 1, 4'h2, 0);
    repeat (5) step(0, 0, 0, 0, 1);
    // R2 reserved code falls back to length 2
    step(1, 1024 + 4095, 3, 4'h7, 1);
    repeat (3) step(0, 0, 0, 0, 1);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 6) == 0, int'($urandom % 8192), int'($urandom % 4),
           int'($urandom % 16), ($urandom % 4) != 0);
    end
    step(0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule